// File: doc/BRIEF.md
# RS-485 Driver Direction Turnaround Timer

This block controls the driver-enable line of an external half-duplex RS-485 transceiver on behalf of a UART transmitter. While the transmitter is sending, the direction output stays in its driving state. When the stop bit of the last queued character is on the wire and the transmit queue is empty, the block keeps the driver enabled for a programmable number of bit times and then lets go. This gives the far end time to see the whole final character before the bus floats or changes direction.

The hold time is an 8-bit count of baud ticks, so it can be anything from 0 to 255 bit periods. The count is taken from the delay input at the moment the hold begins. If the transmitter becomes busy again while the hold is running, the hold is dropped and the driver stays enabled without a break. A polarity input selects whether the pin is active-high or active-low. A one-cycle done flag marks the clock in which the driver is released.

Top module: `rs485_turnaround`

## Requirements
- R1: During and after synchronous reset, `turn_done` is 0 and `dir_pin` sits at its inactive level, which is the value of `pol_low`.
- R2: On the clock after `tx_busy` is sampled high, `dir_pin` is at its active level, which is the inverse of `pol_low`. It stays active while `tx_busy` remains high.
- R3: Suppose `stop_done` and `fifo_empty` are sampled high together and `dly_val` is 0. Then on the next clock `dir_pin` returns to its inactive level and `turn_done` is 1.
- R4: Suppose `stop_done` and `fifo_empty` are sampled high together and `dly_val` is D, where D is greater than 0. Then `dir_pin` stays active until the D-th `bit_tick` sampled after that clock, and it goes inactive on the clock after that tick. A tick in the same cycle as `stop_done` does not count.
- R5: The hold advances only on cycles where `bit_tick` is high. Any number of system clocks without a tick leaves the driver enabled.
- R6: If `stop_done` arrives while `fifo_empty` is 0, no hold starts and `dir_pin` stays active regardless of ticks.
- R7: If `tx_busy` goes high during a hold, the hold is cancelled and `dir_pin` stays active with no inactive cycle. The next end of transmission starts a fresh hold of the full D ticks.
- R8: `dly_val` is captured when the hold starts. Changes to it during the hold do not alter the number of ticks before release.
- R9: `dir_pin` follows `pol_low` with one clock of latency. With `pol_low`=1 the pin is 0 when driving and 1 when idle.
- R10: `turn_done` is high for exactly one clock per release. The maximum delay of 255 ticks is honoured in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per baud bit period |
| tx_busy | input | 1 | Transmitter is sending or about to send a character |
| stop_done | input | 1 | One-cycle strobe when a stop bit has finished on the line |
| fifo_empty | input | 1 | Transmit queue holds no further characters |
| dly_val | input | 8 | Hold time in bit periods |
| pol_low | input | 1 | 1 selects an active-low direction pin |
| dir_pin | output | 1 | Transceiver driver-enable output |
| turn_done | output | 1 | One-cycle flag on the clock the driver is released |

## Verification
The assertions assume the transmitter never holds `tx_busy` high in the same cycle as the final `stop_done`. They also assume `pol_low` is steady across the cycle being checked, and that `bit_tick` and `stop_done` are single-cycle strobes. The bench drops `tx_busy` in exactly the cycle that carries the last `stop_done`. It changes `pol_low` only while the block is idle, and it drives every strobe high for one clock at a falling edge.

// File: rtl/rs485_turn_pkg.sv
package rs485_turn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } turn_state_e;
endpackage

// File: rtl/turn_delay_cnt.sv
// Down-counter timing the driver hold in baud ticks.
module turn_delay_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             cancel,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ZERO;
    end else if (cancel) begin
      cnt <= ZERO;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && (cnt != ZERO)) begin
      cnt <= cnt - ONE;
    end
  end

  assign expire = tick && !load && !cancel && (cnt == ONE);

  AST_CNT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load && !cancel) |=> $stable(cnt)); // R5
endmodule

// File: rtl/turn_ctrl.sv
// State machine: sending, holding after the last stop bit, idle.
module turn_ctrl
  import rs485_turn_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_busy,
  input  logic        stop_done,
  input  logic        fifo_empty,
  input  logic        dly_zero,
  input  logic        expire,
  output logic        load,
  output logic        cancel,
  output logic        drive_nxt,
  output logic        done_nxt,
  output turn_state_e state
);
  turn_state_e state_nxt;
  logic        last_stop;

  assign last_stop = stop_done && fifo_empty;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: if (tx_busy) state_nxt = ST_SEND;
      ST_SEND: if (last_stop) state_nxt = dly_zero ? ST_IDLE : ST_HOLD;
      ST_HOLD: begin
        if (tx_busy)     state_nxt = ST_SEND;
        else if (expire) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  assign load      = (state == ST_SEND) && last_stop && !dly_zero;
  assign cancel    = (state == ST_HOLD) && tx_busy;
  assign drive_nxt = (state_nxt != ST_IDLE);
  assign done_nxt  = (state != ST_IDLE) && (state_nxt == ST_IDLE);

  AST_CANCEL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HOLD) && tx_busy) |=> (state == ST_SEND)); // R7
endmodule

// File: rtl/rs485_turnaround.sv
module rs485_turnaround
  import rs485_turn_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             tx_busy,
  input  logic             stop_done,
  input  logic             fifo_empty,
  input  logic [DLY_W-1:0] dly_val,
  input  logic             pol_low,
  output logic             dir_pin,
  output logic             turn_done
);
  logic             load, cancel, expire, drive_nxt, done_nxt, dly_zero;
  logic [DLY_W-1:0] cnt;
  turn_state_e      state;

  assign dly_zero = (dly_val == '0);

  turn_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .stop_done(stop_done),
    .fifo_empty(fifo_empty), .dly_zero(dly_zero), .expire(expire),
    .load(load), .cancel(cancel), .drive_nxt(drive_nxt),
    .done_nxt(done_nxt), .state(state)
  );

  turn_delay_cnt #(.CNT_W(DLY_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .cancel(cancel), .tick(bit_tick),
    .load_val(dly_val), .cnt(cnt), .expire(expire)
  );

  // Registered pin; pin level = drive XOR active-low select.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_pin   <= pol_low;
      turn_done <= 1'b0;
    end else begin
      dir_pin   <= drive_nxt ^ pol_low;
      turn_done <= done_nxt;
    end
  end

  AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> (dir_pin == !$past(pol_low))); // R2
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    turn_done |-> (dir_pin == $past(pol_low))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    turn_done |=> !turn_done); // R10
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> (cnt != '0)); // R4
endmodule

// File: tb/rs485_turnaround_test.sv
module rs485_turnaround_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0, tx_busy = 1'b0, stop_done = 1'b0, fifo_empty = 1'b1;
  logic [7:0] dly_val = 8'd0;
  logic       pol_low = 1'b0;
  logic       dir_pin, turn_done;
  int         total = 0, bad = 0;
  bit         ended = 1'b0;

  always #2.5 clk = ~clk;

  rs485_turnaround uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .stop_done(stop_done), .fifo_empty(fifo_empty), .dly_val(dly_val),
    .pol_low(pol_low), .dir_pin(dir_pin), .turn_done(turn_done)
  );

  task automatic cyc(); @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic active_lvl(); return ~pol_low; endfunction

  task automatic check_active(input string req);
    check(dir_pin == active_lvl(), req, dir_pin, active_lvl());
  endtask
  task automatic check_idle(input string req);
    check(dir_pin == pol_low, req, dir_pin, pol_low);
  endtask

  task automatic start_char();
    tx_busy = 1'b1; cyc(); check_active("R2");
  endtask

  task automatic end_char(input bit with_tick);
    tx_busy = 1'b0; stop_done = 1'b1; fifo_empty = 1'b1; bit_tick = with_tick;
    cyc();
    stop_done = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic tick_once(input int gap);
    bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
    for (int g = 0; g < gap; g++) cyc();
  endtask

  task automatic run_hold(input int n, input int gap, input string req);
    for (int i = 1; i <= n; i++) begin
      tick_once(0);
      if (i < n) begin
        check_active(req);
        check(turn_done == 1'b0, req, turn_done, 0);
        for (int g = 0; g < gap; g++) cyc();
      end
    end
    check_idle(req);
    check(turn_done == 1'b1, req, turn_done, 1);
    cyc();
    check(turn_done == 1'b0, "R10", turn_done, 0);
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    check_idle("R1"); check(turn_done == 1'b0, "R1", turn_done, 0);
    rst = 1'b0; cyc();
    check_idle("R1"); check(turn_done == 1'b0, "R1", turn_done, 0);
  endtask

  task automatic t_zero();
    dly_val = 8'd0;
    start_char(); repeat (4) cyc(); check_active("R2");
    end_char(1'b0);
    check_idle("R3"); check(turn_done == 1'b1, "R3", turn_done, 1);
    cyc(); check(turn_done == 1'b0, "R10", turn_done, 0);
  endtask

  task automatic t_delay(input int d, input int gap, input string req);
    dly_val = 8'(d);
    start_char(); repeat (2) cyc();
    end_char(1'b1);
    check_active(req);
    for (int g = 0; g < gap; g++) cyc();
    run_hold(d, gap, req);
  endtask

  task automatic t_not_empty();
    dly_val = 8'd2;
    start_char();
    stop_done = 1'b1; fifo_empty = 1'b0; cyc(); stop_done = 1'b0;
    for (int i = 0; i < 4; i++) tick_once(1);
    check_active("R6"); check(turn_done == 1'b0, "R6", turn_done, 0);
    end_char(1'b0); run_hold(2, 0, "R6");
  endtask

  task automatic t_restart();
    dly_val = 8'd5;
    start_char(); end_char(1'b0);
    tick_once(0); tick_once(0);
    tx_busy = 1'b1; cyc(); check_active("R7");
    tick_once(0); tick_once(0); tick_once(0); check_active("R7");
    check(turn_done == 1'b0, "R7", turn_done, 0);
    end_char(1'b0); check_active("R7");
    run_hold(5, 1, "R7");
  endtask

  task automatic t_change_dly();
    dly_val = 8'd3;
    start_char(); end_char(1'b0);
    dly_val = 8'd10;
    run_hold(3, 0, "R8");
  endtask

  task automatic t_polarity();
    pol_low = 1'b1; cyc(); cyc();
    check(dir_pin == 1'b1, "R9", dir_pin, 1);
    dly_val = 8'd1;
    tx_busy = 1'b1; cyc(); check(dir_pin == 1'b0, "R9", dir_pin, 0);
    end_char(1'b0); run_hold(1, 0, "R9");
    check(dir_pin == 1'b1, "R9", dir_pin, 1);
    pol_low = 1'b0; cyc(); cyc();
  endtask

  initial begin
    t_reset();
    t_zero();
    t_delay(4, 0, "R4");
    t_delay(3, 7, "R5");
    t_not_empty();
    t_restart();
    t_change_dly();
    t_polarity();
    t_delay(255, 1, "R10");
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule